// File: doc/BRIEF.md
# DRAM Power-On Wake-Up Sequencer

This block sits between the memory access controller and the DRAM strobe pins. After reset it holds both strobes high for a long power-up pause. It then issues a fixed number of refresh-type wake-up cycles, and only after that does it raise a done flag that releases the access controller and the refresh scheduler. Each wake-up cycle is a CAS-before-RAS refresh: the column strobe falls first, then the row strobe makes one timed low pulse, and then both return high for a precharge gap. Because the device's internal counter supplies the row in this kind of cycle, no address is driven during initialisation.

While the sequence runs, the DRAM pins carry the sequencer's own strobes and the controller's strobes are blocked. Once the sequence is done, the pins pass the controller's strobes through without a register stage. If the refresh logic reports that the retention period was overrun, a pulse on the retrigger input drops the done flag and runs the wake-up cycles again. This rerun skips the power-up pause but starts with one precharge gap. All phase lengths come from nanosecond parameters and a clock-period parameter, rounded up to whole cycles. A simulation bench can shorten the pause by overriding its parameter.

Top module: `dramInitSeq`

## Requirements
- R1: While rstN is low, dramRasN and dramCasN are 1 and initDone is 0.
- R2: After rstN rises, both strobes stay high for exactly PAUSE_CYC = ceil(PAUSE_NS / CLK_PERIOD_NS) clock cycles before any strobe falls.
- R3: In every wake-up cycle, dramCasN is low (0) with dramRasN high (1) for exactly CSR_CYC = ceil(CAS_SETUP_NS / CLK_PERIOD_NS) cycles before dramRasN falls. dramCasN is therefore already low on the cycle that RAS falls.
- R4: Each wake-up RAS pulse holds dramRasN = 0 and dramCasN = 0 for exactly RAS_LOW_CYC = ceil(RAS_LOW_NS / CLK_PERIOD_NS) cycles.
- R5: Each wake-up RAS pulse is followed by a gap of exactly PRE_CYC = ceil(PRECHARGE_NS / CLK_PERIOD_NS) cycles with both strobes high.
- R6: After exactly WAKE_COUNT RAS pulses and the gap that follows the last one, initDone becomes 1 on the next cycle and stays 1 until a retrigger.
- R7: While initDone is 0, ctrlRasN and ctrlCasN have no effect on the pins. The pins never show RAS low with CAS high (dramRasN = 0, dramCasN = 1).
- R8: While initDone is 1, dramRasN equals ctrlRasN and dramCasN equals ctrlCasN in the same cycle, with no register stage.
- R9: When refreshLapsed is 1 at a clock edge while initDone is 1, initDone is 0 from the next cycle. The pins then show one PRE_CYC gap, then WAKE_COUNT wake-up cycles with no pause, and then initDone returns to 1.
- R10: refreshLapsed has no effect while initDone is 0. A pulse during the pause or during the wake-up cycles neither restarts nor lengthens the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts the power-up pause |
| refreshLapsed | input | 1 | Refresh-overdue flag; reruns the wake-up cycles when the sequencer is done |
| ctrlRasN | input | 1 | Row strobe from the access controller |
| ctrlCasN | input | 1 | Column strobe from the access controller |
| dramRasN | output | 1 | Row strobe pin, active low |
| dramCasN | output | 1 | Column strobe pin, active low |
| initDone | output | 1 | 1 when initialisation is complete and the controller owns the pins |

## Verification
The strobe pins are compared as runs of constant (initDone, RAS, CAS) values against an expected list of run lengths. This comparison catches both a wrong phase length and a missing or extra wake-up cycle.

The power-on sequence is run with the controller inputs parked at RAS low with CAS high, a pattern the sequencer never produces, so any leak of controller strobes during initialisation is visible. Retrigger pulses are placed inside the pause and inside a wake-up pulse, and the expected runs must stay unchanged. A retrigger from the done state is checked for the leading precharge gap and for the absence of the pause. All four controller strobe combinations are applied in the done state to show a same-cycle pass-through.

// File: rtl/dramInitPkg.sv
`timescale 1ns/1ps
package dramInitPkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_PRECHARGE,
    ST_DONE
  } initState_t;

  typedef enum logic [1:0] {
    DUR_CAS_SETUP,
    DUR_RAS_LOW,
    DUR_PRECHARGE
  } durSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic    loadTimer;
    durSel_t durSel;
    logic    wakeInc;
    logic    wakeClr;
    logic    initRasN;
    logic    initCasN;
    logic    done;
  } seqStrobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramInitCtrl.sv
`timescale 1ns/1ps
module dramInitCtrl
  import dramInitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshLapsed,
  input  logic       timerZero,
  input  logic       wakeAll,
  output seqStrobe_t strobe
);

  initState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.durSel    = DUR_CAS_SETUP;
    strobe.initRasN  = 1'b1;
    strobe.initCasN  = 1'b1;
    unique case (state)
      ST_PAUSE: begin
        if (timerZero) begin
          stateNext        = ST_CAS_SETUP;
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_CAS_SETUP;
        end
      end
      ST_CAS_SETUP: begin
        strobe.initCasN = 1'b0;
        if (timerZero) begin
          stateNext        = ST_RAS_LOW;
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_RAS_LOW;
        end
      end
      ST_RAS_LOW: begin
        strobe.initRasN = 1'b0;
        strobe.initCasN = 1'b0;
        if (timerZero) begin
          stateNext        = ST_PRECHARGE;
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_PRECHARGE;
          strobe.wakeInc   = 1'b1;
        end
      end
      ST_PRECHARGE: begin
        if (timerZero) begin
          if (wakeAll) begin
            stateNext = ST_DONE;
          end else begin
            stateNext        = ST_CAS_SETUP;
            strobe.loadTimer = 1'b1;
            strobe.durSel    = DUR_CAS_SETUP;
          end
        end
      end
      ST_DONE: begin
        strobe.done = 1'b1;
        if (refreshLapsed) begin
          stateNext        = ST_PRECHARGE;
          strobe.loadTimer = 1'b1;
          strobe.durSel    = DUR_PRECHARGE;
          strobe.wakeClr   = 1'b1;
        end
      end
      default: stateNext = ST_PAUSE;
    endcase
  end

endmodule

// File: rtl/dramInitDatapath.sv
`timescale 1ns/1ps
module dramInitDatapath
  import dramInitPkg::*;
#(
  parameter int PAUSE_CYC   = 20000,
  parameter int CSR_CYC     = 1,
  parameter int RAS_LOW_CYC = 5,
  parameter int PRE_CYC     = 3,
  parameter int WAKE_COUNT  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       ctrlRasN,
  input  logic       ctrlCasN,
  output logic       timerZero,
  output logic       wakeAll,
  output logic       dramRasN,
  output logic       dramCasN
);

  localparam int MAX_CYC = maxOf(maxOf(PAUSE_CYC, CSR_CYC), maxOf(RAS_LOW_CYC, PRE_CYC));
  localparam int TIMER_W = $clog2(MAX_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_COUNT + 1);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] loadVal;
  logic [WAKE_W-1:0]  wakeCnt;

  always_comb begin
    unique case (strobe.durSel)
      DUR_CAS_SETUP: loadVal = TIMER_W'(CSR_CYC - 1);
      DUR_RAS_LOW:   loadVal = TIMER_W'(RAS_LOW_CYC - 1);
      DUR_PRECHARGE: loadVal = TIMER_W'(PRE_CYC - 1);
      default:       loadVal = '0;
    endcase
  end

  // phase timer: reset value covers the power-up pause
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= TIMER_W'(PAUSE_CYC - 1);
    else if (strobe.loadTimer) timer <= loadVal;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wakeCnt <= '0;
    else if (strobe.wakeClr) wakeCnt <= '0;
    else if (strobe.wakeInc) wakeCnt <= wakeCnt + 1'b1;
  end

  assign timerZero = (timer == '0);
  assign wakeAll   = (wakeCnt == WAKE_W'(WAKE_COUNT));

  // pin ownership: sequencer until done, controller afterwards
  assign dramRasN = strobe.done ? ctrlRasN : strobe.initRasN;
  assign dramCasN = strobe.done ? ctrlCasN : strobe.initCasN;

endmodule

// File: rtl/dramInitSeq.sv
`timescale 1ns/1ps
module dramInitSeq
  import dramInitPkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int PAUSE_NS      = 200000,
  parameter int CAS_SETUP_NS  = 10,
  parameter int RAS_LOW_NS    = 50,
  parameter int PRECHARGE_NS  = 30,
  parameter int WAKE_COUNT    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic refreshLapsed,
  input  logic ctrlRasN,
  input  logic ctrlCasN,
  output logic dramRasN,
  output logic dramCasN,
  output logic initDone
);

  localparam int PAUSE_CYC   = nsToCycles(PAUSE_NS, CLK_PERIOD_NS);
  localparam int CSR_CYC     = nsToCycles(CAS_SETUP_NS, CLK_PERIOD_NS);
  localparam int RAS_LOW_CYC = nsToCycles(RAS_LOW_NS, CLK_PERIOD_NS);
  localparam int PRE_CYC     = nsToCycles(PRECHARGE_NS, CLK_PERIOD_NS);

  seqStrobe_t strobe;
  logic       timerZero;
  logic       wakeAll;

  dramInitCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .refreshLapsed (refreshLapsed),
    .timerZero     (timerZero),
    .wakeAll       (wakeAll),
    .strobe        (strobe)
  );

  dramInitDatapath #(
    .PAUSE_CYC   (PAUSE_CYC),
    .CSR_CYC     (CSR_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC),
    .WAKE_COUNT  (WAKE_COUNT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlRasN  (ctrlRasN),
    .ctrlCasN  (ctrlCasN),
    .timerZero (timerZero),
    .wakeAll   (wakeAll),
    .dramRasN  (dramRasN),
    .dramCasN  (dramCasN)
  );

  assign initDone = strobe.done;

endmodule

// File: rtl/dramInitSeqChecker.sv
`timescale 1ns/1ps
module dramInitSeqChecker #(
  parameter int RAS_LOW_CYC = 5
) (
  input logic clk,
  input logic rstN,
  input logic refreshLapsed,
  input logic dramRasN,
  input logic dramCasN,
  input logic initDone
);

  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   lowRun <= '0;
    else if (!dramRasN) begin
      if (lowRun != 16'hFFFF)    lowRun <= lowRun + 1'b1;
    end else                     lowRun <= '0;
  end

  // R3: CAS already low when RAS falls in a wake-up cycle
  a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && $fell(dramRasN)) |-> (!dramCasN && $past(!dramCasN)));

  // R4: wake-up RAS pulse width
  a_r4_ras_low_width: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && $past(!initDone) && $rose(dramRasN)) |-> (lowRun == 16'(RAS_LOW_CYC)));

  // R6: done only follows a precharge gap
  a_r6_done_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(dramRasN && dramCasN));

  // R7: no RAS-low/CAS-high pattern on the pins during init
  a_r7_no_ctrl_leak: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !(!dramRasN && dramCasN));

  // R9: retrigger in done state drops done next cycle
  a_r9_retrigger_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && refreshLapsed) |=> !initDone);

endmodule

bind dramInitSeq dramInitSeqChecker #(
  .RAS_LOW_CYC (RAS_LOW_CYC)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .refreshLapsed (refreshLapsed),
  .dramRasN      (dramRasN),
  .dramCasN      (dramCasN),
  .initDone      (initDone)
);

// File: tb/sim_dramInitSeq.sv
`timescale 1ns/1ps
module sim_dramInitSeq;

  localparam int CLK_NS    = 10;
  localparam int PAUSE_NS  = 400;
  localparam int WAKE      = 8;
  localparam int P_CYC     = (PAUSE_NS + CLK_NS - 1) / CLK_NS;  // 40
  localparam int CSR_CYC   = 1;   // 10 ns
  localparam int RL_CYC    = 5;   // 50 ns
  localparam int PRE_CYC   = 3;   // 30 ns
  localparam int LIMIT_CYC = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refreshLapsed = 1'b0;
  logic ctrlRasN = 1'b0;
  logic ctrlCasN = 1'b1;
  logic dramRasN, dramCasN, initDone;

  always #5 clk = ~clk;

  dramInitSeq #(
    .CLK_PERIOD_NS (CLK_NS),
    .PAUSE_NS      (PAUSE_NS),
    .CAS_SETUP_NS  (10),
    .RAS_LOW_NS    (50),
    .PRECHARGE_NS  (30),
    .WAKE_COUNT    (WAKE)
  ) u0 (
    .clk           (clk),
    .rstN          (rstN),
    .refreshLapsed (refreshLapsed),
    .ctrlRasN      (ctrlRasN),
    .ctrlCasN      (ctrlCasN),
    .dramRasN      (dramRasN),
    .dramCasN      (dramCasN),
    .initDone      (initDone)
  );

  typedef struct {
    logic [2:0] key;   // {initDone, rasN, casN}
    int         len;
    string      tag;
  } runItem_t;

  runItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit monOn   = 1'b0;
  bit ended   = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic pushRun(input logic [2:0] key, input int len, input string tag);
    runItem_t it;
    it.key = key; it.len = len; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushWakeups();
    for (int k = 0; k < WAKE; k++) begin
      pushRun(3'b010, CSR_CYC, "R3");
      pushRun(3'b000, RL_CYC,  "R4");
      pushRun(3'b011, PRE_CYC, (k == WAKE - 1) ? "R6" : "R5");
    end
  endtask

  // monitor: collapse pin samples into runs and compare with the queue
  logic [2:0] runKey;
  int runLen = 0;
  always @(negedge clk) begin
    logic [2:0] key;
    runItem_t it;
    if (monOn) begin
      key = {initDone, dramRasN, dramCasN};
      check(!(!initDone && !dramRasN && dramCasN), "R7", "ras-low/cas-high during init",
            int'({dramRasN, dramCasN}), 3);
      if (runLen == 0) begin
        runKey = key; runLen = 1;
      end else if (key == runKey) begin
        runLen++;
      end else begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected extra run", int'(runKey), 0);
        end else begin
          it = expQ.pop_front();
          check(runKey == it.key, it.tag, "run value", int'(runKey), int'(it.key));
          check(runLen == it.len, it.tag, "run length", runLen, it.len);
        end
        runKey = key; runLen = 1;
      end
    end else begin
      runLen = 0;
    end
  end

  initial begin
    #(LIMIT_CYC * CLK_NS);
    check(1'b0, "R6", "watchdog expired", 0, 1);
    finishRun();
  end

  task automatic waitDone();
    while (!initDone) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1 monOn = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(dramRasN == 1'b1, "R1", "rasN in reset", dramRasN, 1);
    check(dramCasN == 1'b1, "R1", "casN in reset", dramCasN, 1);
    check(initDone == 1'b0, "R1", "initDone in reset", initDone, 0);

    // power-on sequence, controller parked at ras-low/cas-high (R7)
    pushRun(3'b011, P_CYC, "R2");
    pushWakeups();
    @(posedge clk);
    #2 rstN = 1'b1;
    monOn = 1'b1;
    fork
      begin  // R10: retrigger inside the pause
        repeat (10) @(posedge clk);
        #1 refreshLapsed = 1'b1;
        @(posedge clk);
        #1 refreshLapsed = 1'b0;
      end
      begin  // R10: retrigger inside the third RAS pulse
        repeat (P_CYC + 2 * (CSR_CYC + RL_CYC + PRE_CYC) + CSR_CYC + 1) @(posedge clk);
        #1 refreshLapsed = 1'b1;
        @(posedge clk);
        #1 refreshLapsed = 1'b0;
      end
    join
    waitDone();
    check(expQ.size() == 0, "R10", "runs left after power-on", expQ.size(), 0);
    check(initDone == 1'b1, "R6", "initDone after wake-ups", initDone, 1);

    // R8: same-cycle pass-through in done state
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      ctrlRasN = p[1];
      ctrlCasN = p[0];
      #1;
      check(dramRasN == p[1], "R8", "rasN pass-through", dramRasN, p[1]);
      check(dramCasN == p[0], "R8", "casN pass-through", dramCasN, p[0]);
    end

    // R9: retrigger from done, no pause, leading precharge
    @(negedge clk);
    ctrlRasN = 1'b1;
    ctrlCasN = 1'b1;
    pushRun(3'b011, PRE_CYC, "R9");
    pushWakeups();
    @(negedge clk);
    #1 refreshLapsed = 1'b1;
    monOn = 1'b1;
    @(posedge clk);
    #1 refreshLapsed = 1'b0;
    ctrlRasN = 1'b0;   // R7: parked controller must not leak
    ctrlCasN = 1'b1;
    @(negedge clk);
    check(initDone == 1'b0, "R9", "initDone after retrigger", initDone, 0);
    waitDone();
    check(expQ.size() == 0, "R9", "runs left after retrigger", expQ.size(), 0);
    check(initDone == 1'b1, "R9", "initDone after rerun", initDone, 1);
    #1;
    check(dramRasN == ctrlRasN, "R8", "rasN owned by controller", dramRasN, ctrlRasN);

    finishRun();
  end

endmodule